// File: doc/BRIEF.md
# Alternating-Group Cell Balancing Scheduler

This controller drives the balancing switches of a five-cell series stack. Every clock it receives the digitized cell voltages in millivolts, an active-low balance enable, a stack-wide fault flag, a charging flag, a discharge-fault flag and a measurement-window strobe. From these it decides which cells are high enough above the weakest cell to need bleeding. It also decides which cells are in overvoltage and should be bled regardless of charging.

Cells 1, 3 and 5 form the odd group and cells 2 and 4 form the even group. The two groups never conduct together. A period counter grants whole balancing periods to one group at a time. When both groups have work, the grant alternates. When only one group has work, that group keeps every period. All switches drop in the same cycle that the measurement window opens. A cascade output passes the enable, one clock late, to the next device up the stack.

Top module: `cb_balance_ctrl`

## Requirements
- R1: Normal (differential) balancing is active only while `bal_en_n` is 0, `stack_fault` is 0 and `charging` is 1. If any of these conditions fails, no cell is kept for normal balancing.
- R2: A cell is never selected for normal balancing unless its voltage is strictly above START_MV (3800 mV).
- R3: A cell is selected when it exceeds min_cell + gap, where gap = (`cfg_gap_code`+1)*50 mV. Once selected, it stays selected while above min_cell + gap/2, and it is released at or below that level.
- R4: The odd group is cells at bit positions 0, 2 and 4 of `fet_on`. The even group is bits 1 and 3. A bit of each group is never set in the same cycle.
- R5: Group grants change only at period boundaries (PERIOD_CYC clocks). With both groups requesting, each group receives exactly PERIOD_CYC of every 2*PERIOD_CYC cycles. A lone requesting group keeps every period.
- R6: While `meas_win` is 1, `fet_on` is all zero in that same cycle.
- R7: Overvoltage balancing starts when a cell is at or above `ov_mv`, with `bal_en_n` 0 and `dsg_fault` 0. It does not depend on `charging` or `stack_fault`. A discharge fault clears it.
- R8: Overvoltage balancing stops when the cell falls to or below the higher of `ov_mv` - (`cfg_ovgap_code`+1)*50 and `ov_mv` - `ov_hys_mv`.
- R9: `cascade_n` equals `bal_en_n` delayed by one clock. It is 1 in reset.
- R10: Reset clears every switch enable and starts the scheduler in the odd phase. A change on the inputs reaches `fet_on` after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_mv | input | NCELL*VW | Cell voltages in mV; cell 1 in the low slice |
| bal_en_n | input | 1 | Balancing enable, active low |
| stack_fault | input | 1 | A fault exists somewhere in the stack |
| charging | input | 1 | Pack is being charged |
| dsg_fault | input | 1 | Discharge fault somewhere in the stack |
| meas_win | input | 1 | Measurement window; forces all switches off |
| cfg_gap_code | input | 2 | Balancing threshold gap code, 50 mV steps |
| cfg_ovgap_code | input | 2 | Overvoltage to full-charge gap code, 50 mV steps |
| ov_mv | input | VW | Overvoltage level in mV |
| ov_hys_mv | input | VW | Overvoltage hysteresis in mV |
| fet_on | output | NCELL | Balancing switch enables, bit 0 is cell 1 |
| cascade_n | output | 1 | Enable passed to the next device up |

## Verification
The assertions assume a few things about the inputs. Cell voltages and `ov_mv` stay in a range where min_cell plus a 200 mV gap fits in one extra bit. `ov_mv` also sits above START_MV, and the inputs settle between edges. The random stimulus keeps cells between 3700 and 4299 mV and holds `ov_mv` at 4200 mV. Before each scenario it clears the hysteresis state by dropping the enable and charging, so the expected grant can be computed from the set conditions alone. Directed cases then cover the release levels, the gap codes and the cascade delay.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic {PH_ODD = 1'b0, PH_EVEN = 1'b1} cb_phase_e;

  // Gap in mV selected by a 2-bit code: 50, 100, 150, 200
  function automatic logic [8:0] code_to_mv(input logic [1:0] code);
    return 9'(({7'd0, code} + 9'd1) * 9'd50);
  endfunction
endpackage

// File: rtl/cb_min_find.sv
module cb_min_find #(
  parameter int NCELL = 5,
  parameter int VW    = 13
) (
  input  logic [NCELL*VW-1:0] cells_i,
  output logic [VW-1:0]       min_o
);
  always_comb begin
    min_o = cells_i[VW-1:0];
    for (int i = 1; i < NCELL; i++) begin
      if (cells_i[i*VW +: VW] < min_o) min_o = cells_i[i*VW +: VW];
    end
  end
endmodule

// File: rtl/cb_cell_eval.sv
module cb_cell_eval #(
  parameter int VW       = 13,
  parameter int START_MV = 3800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] v_i,
  input  logic [VW:0]   upper_i,
  input  logic [VW:0]   lower_i,
  input  logic          norm_ok_i,
  input  logic          ov_ok_i,
  input  logic [VW-1:0] ov_mv_i,
  input  logic [VW-1:0] stop_mv_i,
  output logic          need_o,
  output logic          ov_o
);
  localparam int GW = VW + 1;
  localparam logic [GW-1:0] START = GW'(START_MV);

  logic [GW-1:0] v_ext;
  logic need_q, need_d, ov_q, ov_d;

  assign v_ext = {1'b0, v_i};

  always_comb begin
    if (!norm_ok_i)  need_d = 1'b0;
    else if (need_q) need_d = (v_ext > lower_i) && (v_ext > START);
    else             need_d = (v_ext > upper_i) && (v_ext > START);
  end

  always_comb begin
    if (!ov_ok_i)  ov_d = 1'b0;
    else if (ov_q) ov_d = (v_i > stop_mv_i);
    else           ov_d = (v_i >= ov_mv_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      need_q <= need_d;
      ov_q   <= ov_d;
    end
  end

  assign need_o = need_q;
  assign ov_o   = ov_q;

  assert_norm_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_ok_i |=> !need_q);
  assert_ov_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_ok_i |=> !ov_q);
endmodule

// File: rtl/cb_group_sched.sv
module cb_group_sched
  import cb_pkg::*;
#(
  parameter int NCELL      = 5,
  parameter int PERIOD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] want_i,
  output logic [NCELL-1:0] fet_o
);
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [NCELL-1:0] odd_mask, even_mask;
  for (genvar g = 0; g < NCELL; g++) begin : g_mask
    assign odd_mask[g]  = (g % 2 == 0);
    assign even_mask[g] = (g % 2 == 1);
  end

  logic [CW-1:0]    cnt_q, cnt_d;
  cb_phase_e        phase_q, phase_d;
  logic [NCELL-1:0] fet_q, fet_d;
  logic             boundary, odd_req, even_req;

  assign boundary = (cnt_q == LAST);
  assign odd_req  = |(want_i & odd_mask);
  assign even_req = |(want_i & even_mask);

  always_comb begin
    cnt_d   = boundary ? '0 : cnt_q + 1'b1;
    phase_d = phase_q;
    if (boundary) begin
      if (odd_req && even_req) phase_d = (phase_q == PH_ODD) ? PH_EVEN : PH_ODD;
      else if (odd_req)        phase_d = PH_ODD;
      else if (even_req)       phase_d = PH_EVEN;
    end
    fet_d = want_i & ((phase_q == PH_ODD) ? odd_mask : even_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_ODD;
      fet_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      fet_q   <= fet_d;
    end
  end

  assign fet_o = fet_q;

  assert_group_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(fet_q & odd_mask) && |(fet_q & even_mask)));
  assert_phase_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(phase_q));
endmodule

// File: rtl/cb_balance_ctrl.sv
module cb_balance_ctrl
  import cb_pkg::*;
#(
  parameter int NCELL      = 5,
  parameter int VW         = 13,
  parameter int START_MV   = 3800,
  parameter int PERIOD_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCELL*VW-1:0] cell_mv,
  input  logic               bal_en_n,
  input  logic               stack_fault,
  input  logic               charging,
  input  logic               dsg_fault,
  input  logic               meas_win,
  input  logic [1:0]         cfg_gap_code,
  input  logic [1:0]         cfg_ovgap_code,
  input  logic [VW-1:0]      ov_mv,
  input  logic [VW-1:0]      ov_hys_mv,
  output logic [NCELL-1:0]   fet_on,
  output logic               cascade_n
);
  localparam int GW = VW + 1;

  logic [VW-1:0]    min_mv;
  logic [GW-1:0]    gap, upper, lower;
  logic [VW-1:0]    ovgap, fc_lvl, hy_lvl, stop_lvl;
  logic             norm_ok, ov_ok, casc_q;
  logic [NCELL-1:0] need, ovact, want, fet_q;

  cb_min_find #(.NCELL(NCELL), .VW(VW)) u_min (
    .cells_i(cell_mv), .min_o(min_mv));

  assign gap   = GW'(code_to_mv(cfg_gap_code));
  assign upper = {1'b0, min_mv} + gap;
  assign lower = {1'b0, min_mv} + (gap >> 1);

  assign ovgap    = VW'(code_to_mv(cfg_ovgap_code));
  assign fc_lvl   = (ov_mv >= ovgap) ? ov_mv - ovgap : '0;
  assign hy_lvl   = (ov_mv >= ov_hys_mv) ? ov_mv - ov_hys_mv : '0;
  assign stop_lvl = (fc_lvl > hy_lvl) ? fc_lvl : hy_lvl;

  assign norm_ok = !bal_en_n && !stack_fault && charging;
  assign ov_ok   = !bal_en_n && !dsg_fault;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    cb_cell_eval #(.VW(VW), .START_MV(START_MV)) u_eval (
      .clk(clk), .rst_n(rst_n), .v_i(cell_mv[c*VW +: VW]),
      .upper_i(upper), .lower_i(lower), .norm_ok_i(norm_ok), .ov_ok_i(ov_ok),
      .ov_mv_i(ov_mv), .stop_mv_i(stop_lvl), .need_o(need[c]), .ov_o(ovact[c]));
  end

  assign want = need | ovact;

  cb_group_sched #(.NCELL(NCELL), .PERIOD_CYC(PERIOD_CYC)) u_sched (
    .clk(clk), .rst_n(rst_n), .want_i(want), .fet_o(fet_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b1;
    else        casc_q <= bal_en_n;
  end

  assign cascade_n = casc_q;
  assign fet_on    = meas_win ? '0 : fet_q;

  assert_meas_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_win |-> (fet_on == '0));
  assert_cascade_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cascade_n == $past(bal_en_n)));
  assert_fet_needs_want_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fet_on & ~$past(want)) == '0));
endmodule

// File: tb/tb_cb_balance_ctrl.sv
module tb_cb_balance_ctrl;
  localparam int NCELL = 5;
  localparam int VW    = 13;
  localparam int P     = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCELL*VW-1:0] cell_mv;
  logic bal_en_n, stack_fault, charging, dsg_fault, meas_win;
  logic [1:0] cfg_gap_code, cfg_ovgap_code;
  logic [VW-1:0] ov_mv, ov_hys_mv;
  logic [NCELL-1:0] fet_on;
  logic cascade_n;

  int vc [NCELL];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cb_balance_ctrl #(.NCELL(NCELL), .VW(VW), .START_MV(3800), .PERIOD_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .cell_mv(cell_mv), .bal_en_n(bal_en_n),
    .stack_fault(stack_fault), .charging(charging), .dsg_fault(dsg_fault),
    .meas_win(meas_win), .cfg_gap_code(cfg_gap_code), .cfg_ovgap_code(cfg_ovgap_code),
    .ov_mv(ov_mv), .ov_hys_mv(ov_hys_mv), .fet_on(fet_on), .cascade_n(cascade_n));

  localparam logic [NCELL-1:0] ODDM = 5'b10101;
  localparam logic [NCELL-1:0] EVNM = 5'b01010;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pack();
    for (int i = 0; i < NCELL; i++) cell_mv[i*VW +: VW] = VW'(vc[i]);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Steady-state want mask from a clean (no hysteresis) history
  function automatic logic [NCELL-1:0] exp_want(input bit nok, input bit ook,
                                                input int gcode, input int ov);
    int mn = vc[0];
    logic [NCELL-1:0] w = '0;
    for (int i = 1; i < NCELL; i++) if (vc[i] < mn) mn = vc[i];
    for (int i = 0; i < NCELL; i++) begin
      if (nok && vc[i] > 3800 && vc[i] > mn + (gcode + 1) * 50) w[i] = 1'b1;
      if (ook && vc[i] >= ov) w[i] = 1'b1;
    end
    return w;
  endfunction

  task automatic clean();
    bal_en_n = 1'b1; charging = 1'b0; stack_fault = 1'b0; dsg_fault = 1'b0;
    meas_win = 1'b0;
    step(3);
  endtask

  task automatic set_all(input int mv);
    for (int i = 0; i < NCELL; i++) vc[i] = mv;
    pack();
  endtask

  // Observe 2*P cycles; check exclusivity, subset, union and time shares
  task automatic observe(input logic [NCELL-1:0] w, input string tag);
    logic [NCELL-1:0] uni = '0;
    int no = 0, ne = 0;
    bit mix = 0, extra = 0;
    for (int i = 0; i < 2 * P; i++) begin
      step(1);
      uni |= fet_on;
      if (|(fet_on & ODDM) && |(fet_on & EVNM)) mix = 1;
      if ((fet_on & ~w) != '0) extra = 1;
      if (|(fet_on & ODDM)) no++;
      if (|(fet_on & EVNM)) ne++;
    end
    chk(!mix, {tag, " R4 groups mixed"}, mix, 0);
    chk(!extra, {tag, " R1 unexpected cell"}, extra, 0);
    chk(uni == w, {tag, " union"}, uni, w);
    if (|(w & ODDM) && |(w & EVNM)) begin
      chk(no == P && ne == P, {tag, " R5 share"}, no * 256 + ne, P * 256 + P);
    end else if (w != '0) begin
      chk(no + ne == 2 * P, {tag, " R5 lone group keeps all"}, no + ne, 2 * P);
    end
  endtask

  initial begin
    int unused;
    logic [NCELL-1:0] w;
    unused = $urandom(32'h5EED);
    rst_n = 1'b0;
    cfg_gap_code = 2'd1; cfg_ovgap_code = 2'd0;
    ov_mv = 13'd4200; ov_hys_mv = 13'd100;
    bal_en_n = 1'b0; charging = 1'b1; stack_fault = 1'b0; dsg_fault = 1'b0;
    meas_win = 1'b0;
    set_all(3850); vc[0] = 4000; vc[1] = 4000; pack();
    step(2);
    chk(fet_on == '0, "R10 reset fet", fet_on, 0);
    chk(cascade_n == 1'b1, "R9 reset cascade", cascade_n, 1);
    rst_n = 1'b1;
    step(3);
    chk(fet_on == 5'b00001, "R10 odd phase first", fet_on, 1);

    // R9 cascade delay
    bal_en_n = 1'b1;
    #1 chk(cascade_n == 1'b0, "R9 cascade before edge", cascade_n, 0);
    step(1);
    chk(cascade_n == 1'b1, "R9 cascade after edge", cascade_n, 1);

    // R5 even-only
    clean(); set_all(3850); vc[3] = 4000; pack();
    bal_en_n = 1'b0; charging = 1'b1;
    step(P + 4);
    observe(5'b01000, "even-only");

    // R5 both groups
    clean(); set_all(3850); vc[0] = 4000; vc[1] = 4000; vc[4] = 4100; pack();
    bal_en_n = 1'b0; charging = 1'b1;
    step(2 * P + 4);
    observe(5'b10011, "both groups");

    // R6 measurement window same cycle
    meas_win = 1'b1;
    #1 chk(fet_on == '0, "R6 meas blank", fet_on, 0);
    step(2);
    chk(fet_on == '0, "R6 meas held", fet_on, 0);
    meas_win = 1'b0;

    // R3 hysteresis, gap 100 -> set >3950, hold >3900
    clean(); cfg_gap_code = 2'd1; set_all(3850); vc[2] = 3960; pack();
    bal_en_n = 1'b0; charging = 1'b1;
    step(P + 4);
    chk(fet_on == 5'b00100, "R3 set above upper", fet_on, 4);
    vc[2] = 3920; pack(); step(4);
    chk(fet_on == 5'b00100, "R3 held above lower", fet_on, 4);
    vc[2] = 3900; pack(); step(4);
    chk(fet_on == 5'b00000, "R3 released at lower", fet_on, 0);
    vc[2] = 3940; pack(); step(4);
    chk(fet_on == 5'b00000, "R3 not reset below upper", fet_on, 0);
    cfg_gap_code = 2'd3; vc[2] = 4040; pack(); step(4);
    chk(fet_on == 5'b00000, "R3 gap 200 not reached", fet_on, 0);
    vc[2] = 4060; pack(); step(4);
    chk(fet_on == 5'b00100, "R3 gap 200 exceeded", fet_on, 4);

    // R2 start voltage
    clean(); cfg_gap_code = 2'd0; set_all(3700); vc[0] = 3790; pack();
    bal_en_n = 1'b0; charging = 1'b1; step(P + 4);
    chk(fet_on == '0, "R2 below start", fet_on, 0);
    vc[0] = 3810; pack(); step(4);
    chk(fet_on == 5'b00001, "R2 above start", fet_on, 1);

    // R1 gating
    stack_fault = 1'b1; step(4);
    chk(fet_on == '0, "R1 stack fault", fet_on, 0);
    stack_fault = 1'b0; charging = 1'b0; step(4);
    chk(fet_on == '0, "R1 not charging", fet_on, 0);

    // R7/R8 overvoltage with charging off
    clean(); set_all(3850); cfg_ovgap_code = 2'd0; vc[3] = 4250; pack();
    bal_en_n = 1'b0; stack_fault = 1'b1; step(P + 4);
    chk(fet_on == 5'b01000, "R7 ov without charging", fet_on, 8);
    vc[3] = 4160; pack(); step(4);
    chk(fet_on == 5'b01000, "R8 held above full-charge", fet_on, 8);
    vc[3] = 4150; pack(); step(4);
    chk(fet_on == '0, "R8 stop at full-charge", fet_on, 0);
    cfg_ovgap_code = 2'd3; vc[3] = 4200; pack(); step(4);
    chk(fet_on == 5'b01000, "R7 ov at level", fet_on, 8);
    vc[3] = 4120; pack(); step(4);
    chk(fet_on == 5'b01000, "R8 held above hys level", fet_on, 8);
    vc[3] = 4100; pack(); step(4);
    chk(fet_on == '0, "R8 stop at hys level", fet_on, 0);
    vc[3] = 4300; pack(); dsg_fault = 1'b1; step(4);
    chk(fet_on == '0, "R7 dsg fault blocks", fet_on, 0);

    // Random scenarios
    for (int t = 0; t < 40; t++) begin
      int gc;
      bit sf, ch;
      clean();
      gc = int'($urandom % 4);
      sf = ($urandom % 5) == 0;
      ch = ($urandom % 4) != 0;
      cfg_gap_code = 2'(gc);
      cfg_ovgap_code = 2'($urandom % 4);
      for (int i = 0; i < NCELL; i++) vc[i] = 3700 + int'($urandom % 600);
      pack();
      w = exp_want(!sf && ch, 1'b1, gc, 4200);
      bal_en_n = 1'b0; stack_fault = sf; charging = ch;
      step(2 * P + 4);
      observe(w, $sformatf("R1 random %0d", t));
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule